// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves control transfers for a 16-bit compressed instruction set. Each cycle it can accept one decoded branch-class instruction. It receives the instruction kind, the raw offset field, the condition code, the current PC value (the instruction address plus 4), the current link register, an exchange operand and the N, Z, C and V flags. One clock later it reports whether the PC is redirected, the new PC, an optional new link register value, an optional instruction-set mode bit, and a one-cycle flush request for the fetch stage.

Five kinds of instruction are handled. A conditional branch uses a short signed offset. An unconditional jump uses a long signed offset. A long call is split across two halfwords: the first half parks the upper part of the offset in the link register, and the second half adds the lower part and leaves a return address. An exchange branch jumps to a register and takes the new instruction-set mode from bit 0 of that register. Fetch and register writeback are outside the block. The link and mode outputs are write requests for the register file and the mode state.

Top module: `bru_top`

## Requirements
- R1: For kind code 0 (conditional), when the condition holds, the new PC is the PC input plus two times the sign-extended offset bits [7:0]. Offset bits [10:8] have no effect on the new PC.
- R2: The condition code values are 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C and !Z), 9 LS (!C or Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z and N==V) and 13 LE (Z or N!=V). Codes 14 and 15 are never taken. A condition that fails gives no redirect.
- R3: For kind code 1 (unconditional jump), the PC is always redirected to the PC input plus the 11-bit offset, sign-extended and shifted left by 1.
- R4: For kind code 2 (first call half), the link output is the PC input plus the 11-bit offset, sign-extended and shifted left by 12. Link write is raised, and there is no redirect and no flush.
- R5: For kind code 3 (second call half), the new PC is the link input plus the 11-bit offset, zero-extended and shifted left by 1. The link output is (PC input - 2) with bit 0 set, and link write is raised.
- R6: For kind code 4 (exchange), the unit always redirects. The mode output is bit 0 of the operand and mode write is raised. The target is the operand with bit 0 cleared; when the operand-is-PC input is high, bit 1 is also cleared.
- R7: All outputs appear one clock after the accepting edge and last one cycle. A cycle with valid low yields taken, flush, link write and mode write all low. Flush is high exactly when taken is high.
- R8: While synchronous reset is high, every output is zero on the next edge, even if a valid instruction is presented.
- R9: Kind codes 5, 6 and 7 raise neither taken, flush, link write nor mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| kind_i | input | 3 | Instruction kind code (0..4 used) |
| cond_i | input | 4 | Condition code for kind 0 |
| offset_i | input | 11 | Raw offset field |
| pc_i | input | 32 | Instruction address plus 4 |
| link_i | input | 32 | Current link register value |
| xreg_i | input | 32 | Exchange operand value |
| xreg_is_pc_i | input | 1 | Exchange operand is the PC register |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| taken_o | output | 1 | PC is redirected |
| flush_o | output | 1 | One-cycle flush request to fetch |
| new_pc_o | output | 32 | Redirect target, meaningful with taken_o |
| link_we_o | output | 1 | Link register write request |
| link_o | output | 32 | Value for the link register |
| mode_we_o | output | 1 | Mode bit write request |
| mode_o | output | 1 | New instruction-set mode |

## Verification
Every condition code is tried with one flag pattern that makes it pass and, for most codes, one that makes it fail. For the signed comparisons, N and V are set together so that GE and LT split on the same flags. Offsets at the positive and negative extremes of both the 8-bit and 11-bit fields expose a wrong sign-extension width or shift. A conditional offset with its upper three bits set shows that those bits are dropped. Exchange operands with bit 0 and bit 1 set in turn, with and without the operand-is-PC flag, separate the mode extraction from the two alignment masks. Back-to-back vectors followed by an idle cycle and a reset that arrives together with a valid branch show that outputs last a single cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int unsigned XLEN       = 32;
    localparam int unsigned OFF_W      = 11;
    localparam int unsigned COFF_W     = 8;
    localparam int unsigned HI_SHIFT   = 12;
    localparam int unsigned COND_W     = 4;
    localparam int unsigned KIND_W     = 3;
    localparam int unsigned INSN_BYTES = 2;

    typedef enum logic [KIND_W-1:0] {
        BK_COND    = 3'd0,
        BK_JUMP    = 3'd1,
        BK_CALL_HI = 3'd2,
        BK_CALL_LO = 3'd3,
        BK_EXCH    = 3'd4
    } br_kind_e;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13
    } cond_code_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic            redirect;
        logic [XLEN-1:0] target;
        logic            link_we;
        logic [XLEN-1:0] link;
        logic            mode_we;
        logic            mode;
    } br_result_t;

    // Condition test over the four flags; unlisted codes never pass.
    function automatic logic cond_holds(input logic [COND_W-1:0] code, input flags_t f);
        logic r;
        case (code)
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  flags_t            flags_i,
    output logic              pass_o
);
    always_comb begin
        pass_o = cond_holds(cond_i, flags_i);
    end
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc
    import bru_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    input  logic              cond_pass_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   link_i,
    input  logic [XLEN-1:0]   xreg_i,
    input  logic              xreg_is_pc_i,
    output br_result_t        res_o
);
    localparam int unsigned SHORT_PAD = XLEN - COFF_W - 1;
    localparam int unsigned LONG_PAD  = XLEN - OFF_W - 1;
    localparam int unsigned HIGH_PAD  = XLEN - OFF_W - HI_SHIFT;

    logic [XLEN-1:0] short_disp;
    logic [XLEN-1:0] long_disp;
    logic [XLEN-1:0] high_disp;
    logic [XLEN-1:0] low_disp;
    logic [XLEN-1:0] return_addr;
    logic [XLEN-1:0] exch_mask;

    always_comb begin
        short_disp  = {{SHORT_PAD{offset_i[COFF_W-1]}}, offset_i[COFF_W-1:0], 1'b0};
        long_disp   = {{LONG_PAD{offset_i[OFF_W-1]}}, offset_i, 1'b0};
        high_disp   = {{HIGH_PAD{offset_i[OFF_W-1]}}, offset_i, {HI_SHIFT{1'b0}}};
        low_disp    = {{LONG_PAD{1'b0}}, offset_i, 1'b0};
        return_addr = (pc_i - XLEN'(INSN_BYTES)) | XLEN'(1);
        exch_mask   = xreg_is_pc_i ? ~XLEN'(3) : ~XLEN'(1);
    end

    always_comb begin
        res_o = '0;
        case (kind_i)
            BK_COND: begin
                res_o.redirect = cond_pass_i;
                res_o.target   = pc_i + short_disp;
            end
            BK_JUMP: begin
                res_o.redirect = 1'b1;
                res_o.target   = pc_i + long_disp;
            end
            BK_CALL_HI: begin
                res_o.link_we = 1'b1;
                res_o.link    = pc_i + high_disp;
            end
            BK_CALL_LO: begin
                res_o.redirect = 1'b1;
                res_o.target   = link_i + low_disp;
                res_o.link_we  = 1'b1;
                res_o.link     = return_addr;
            end
            BK_EXCH: begin
                res_o.redirect = 1'b1;
                res_o.target   = xreg_i & exch_mask;
                res_o.mode_we  = 1'b1;
                res_o.mode     = xreg_i[0];
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/bru_result_reg.sv
module bru_result_reg
    import bru_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  br_result_t res_i,
    output br_result_t res_q,
    output logic       flush_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flush_q <= 1'b0;
        end else if (valid_i) begin
            res_q   <= res_i;
            flush_q <= res_i.redirect;
        end else begin
            res_q   <= '0;
            flush_q <= 1'b0;
        end
    end

    AST_FLUSH_TRACKS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        flush_q == res_q.redirect); // R7
endmodule

// File: rtl/bru_top.sv
module bru_top
    import bru_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   link_i,
    input  logic [XLEN-1:0]   xreg_i,
    input  logic              xreg_is_pc_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              flag_v_i,
    output logic              taken_o,
    output logic              flush_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic              link_we_o,
    output logic [XLEN-1:0]   link_o,
    output logic              mode_we_o,
    output logic              mode_o
);
    flags_t     flags;
    logic       cond_pass;
    br_result_t res_d;
    br_result_t res_q;
    logic       flush_q;

    assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

    bru_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags),
        .pass_o  (cond_pass)
    );

    bru_target_calc u_calc (
        .kind_i       (kind_i),
        .cond_pass_i  (cond_pass),
        .offset_i     (offset_i),
        .pc_i         (pc_i),
        .link_i       (link_i),
        .xreg_i       (xreg_i),
        .xreg_is_pc_i (xreg_is_pc_i),
        .res_o        (res_d)
    );

    bru_result_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .res_i   (res_d),
        .res_q   (res_q),
        .flush_q (flush_q)
    );

    assign taken_o   = res_q.redirect;
    assign flush_o   = flush_q;
    assign new_pc_o  = res_q.target;
    assign link_we_o = res_q.link_we;
    assign link_o    = res_q.link;
    assign mode_we_o = res_q.mode_we;
    assign mode_o    = res_q.mode;

    AST_RESERVED_COND_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i) && $past(kind_i) == BK_COND && $past(cond_i) >= 4'd14)
        |-> !taken_o); // R2
    AST_CALL_HI_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i) && $past(kind_i) == BK_CALL_HI)
        |-> (link_we_o && !taken_o && !flush_o)); // R4
    AST_CALL_LO_LINK_ODD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i) && $past(kind_i) == BK_CALL_LO)
        |-> (link_we_o && link_o[0] && taken_o)); // R5
    AST_EXCH_MODE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i) && $past(kind_i) == BK_EXCH)
        |-> (taken_o && !new_pc_o[0] && mode_we_o && mode_o == $past(xreg_i[0]))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(valid_i))
        |-> !(taken_o || flush_o || link_we_o || mode_we_o)); // R7
    AST_UNUSED_KIND: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i) && $past(kind_i) > 3'd4)
        |-> !(taken_o || link_we_o || mode_we_o)); // R9
endmodule

// File: tb/sim_bru_top.sv
module sim_bru_top;
    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  cond;
        logic [10:0] off;
        logic [3:0]  nzcv;
        logic [31:0] pc;
        logic [31:0] link;
        logic [31:0] xreg;
        logic        xpc;
        logic        e_taken;
        logic [31:0] e_pc;
        logic        e_lwe;
        logic [31:0] e_link;
        logic        e_mwe;
        logic        e_mode;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 4'd0,  11'h010, 4'b0100, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h1024, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd0,  11'h010, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd1,  11'h7FE, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd2,  11'h004, 4'b0010, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h100C, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd3,  11'h004, 4'b0010, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd4,  11'h004, 4'b1000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h100C, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd5,  11'h004, 4'b1000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd6,  11'h004, 4'b0001, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h100C, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd7,  11'h004, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h100C, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd8,  11'h080, 4'b0010, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0F04, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd8,  11'h080, 4'b0110, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd9,  11'h004, 4'b0010, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd9,  11'h004, 4'b0110, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h100C, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd10, 11'h001, 4'b1001, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h1006, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd11, 11'h001, 4'b1001, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd12, 11'h07F, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h1102, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd13, 11'h002, 4'b1000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h1008, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd14, 11'h004, 4'b1111, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd0, 4'd15, 11'h004, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd1, 4'd0,  11'h400, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h0804, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd1, 4'd14, 11'h3FF, 4'b0000, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b1, 32'h1802, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd2, 4'd0,  11'h001, 4'b0100, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b1, 32'h2004, 1'b0, 1'b0},
        '{3'd2, 4'd0,  11'h7FF, 4'b0100, 32'h1004, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0,    1'b1, 32'h0004, 1'b0, 1'b0},
        '{3'd3, 4'd0,  11'h010, 4'b0000, 32'h1006, 32'h2004, 32'h0, 1'b0, 1'b1, 32'h2024, 1'b1, 32'h1005, 1'b0, 1'b0},
        '{3'd4, 4'd0,  11'h000, 4'b0000, 32'h1004, 32'h0, 32'h3001, 1'b0, 1'b1, 32'h3000, 1'b0, 32'h0, 1'b1, 1'b1},
        '{3'd4, 4'd0,  11'h000, 4'b0000, 32'h1004, 32'h0, 32'h3002, 1'b0, 1'b1, 32'h3002, 1'b0, 32'h0, 1'b1, 1'b0},
        '{3'd4, 4'd0,  11'h000, 4'b0000, 32'h1004, 32'h0, 32'h1006, 1'b1, 1'b1, 32'h1004, 1'b0, 32'h0, 1'b1, 1'b0},
        '{3'd4, 4'd0,  11'h000, 4'b0000, 32'h1004, 32'h0, 32'h1007, 1'b1, 1'b1, 32'h1004, 1'b0, 32'h0, 1'b1, 1'b1},
        '{3'd5, 4'd0,  11'h010, 4'b0100, 32'h1004, 32'h2004, 32'h3001, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0},
        '{3'd7, 4'd0,  11'h010, 4'b0100, 32'h1004, 32'h2004, 32'h3001, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [3:0]  cond_i = '0;
    logic [10:0] offset_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] link_i = '0;
    logic [31:0] xreg_i = '0;
    logic        xreg_is_pc_i = 1'b0;
    logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0, flag_v_i = 1'b0;
    logic        taken_o, flush_o, link_we_o, mode_we_o, mode_o;
    logic [31:0] new_pc_o, link_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bru_top u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .kind_i(kind_i), .cond_i(cond_i),
        .offset_i(offset_i), .pc_i(pc_i), .link_i(link_i), .xreg_i(xreg_i),
        .xreg_is_pc_i(xreg_is_pc_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
        .flag_c_i(flag_c_i), .flag_v_i(flag_v_i), .taken_o(taken_o), .flush_o(flush_o),
        .new_pc_o(new_pc_o), .link_we_o(link_we_o), .link_o(link_o),
        .mode_we_o(mode_we_o), .mode_o(mode_o)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] k, input logic [3:0] c);
        case (k)
            3'd0: return (c >= 4'd8) ? "R2" : "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input vec_t v);
        valid_i = 1'b1;
        kind_i = v.kind; cond_i = v.cond; offset_i = v.off;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = v.nzcv;
        pc_i = v.pc; link_i = v.link; xreg_i = v.xreg; xreg_is_pc_i = v.xpc;
    endtask

    task automatic check_quiet(input string tag);
        check(tag, "taken", {31'b0, taken_o}, 32'd0);
        check(tag, "flush", {31'b0, flush_o}, 32'd0);
        check(tag, "link_we", {31'b0, link_we_o}, 32'd0);
        check(tag, "mode_we", {31'b0, mode_we_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", "new_pc", new_pc_o, 32'd0);
        check("R8", "link", link_o, 32'd0);
        check_quiet("R8");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string t;
            apply(VEC[i]);
            t = tag_of(VEC[i].kind, VEC[i].cond);
            @(negedge clk);
            check(t, "taken", {31'b0, taken_o}, {31'b0, VEC[i].e_taken});
            check("R7", "flush", {31'b0, flush_o}, {31'b0, VEC[i].e_taken});
            if (VEC[i].e_taken) check(t, "new_pc", new_pc_o, VEC[i].e_pc);
            check(t, "link_we", {31'b0, link_we_o}, {31'b0, VEC[i].e_lwe});
            if (VEC[i].e_lwe) check(t, "link", link_o, VEC[i].e_link);
            check(t, "mode_we", {31'b0, mode_we_o}, {31'b0, VEC[i].e_mwe});
            if (VEC[i].e_mwe) check(t, "mode", {31'b0, mode_o}, {31'b0, VEC[i].e_mode});
        end

        // R7: idle cycle after a redirect drops every strobe
        apply(VEC[19]);
        @(negedge clk);
        check("R7", "taken before idle", {31'b0, taken_o}, 32'd1);
        valid_i = 1'b0;
        @(negedge clk);
        check_quiet("R7");

        // R8: reset arriving together with a valid branch
        apply(VEC[24]);
        rst = 1'b1;
        @(negedge clk);
        check_quiet("R8");
        check("R8", "new_pc under reset", new_pc_o, 32'd0);
        rst = 1'b0;
        valid_i = 1'b0;
        @(negedge clk);
        check_quiet("R7");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule